// File: doc/BRIEF.md
# Receive frame status queue

This block keeps a small first-in, first-out record of received infrared frames. At the end of every frame the receive framer raises a one-cycle `frameDone` strobe together with the frame's byte count and its CRC-error and physical-error indications. The block stores one entry per frame. Each entry holds the count, both error indications and an over-length flag. The over-length flag is worked out on entry from a programmable 13-bit maximum.

Software reads the queue through a byte-wide read port with three addresses. A status byte reports whether the oldest entry is valid, that entry's three error flags, and three global sticky conditions. These are frames lost to a full queue, receive-data overrun reported by the framer, and status-queue overrun. Two further bytes give the oldest entry's length. Reading the upper length byte retires that entry. A mode input lets the lower length address return a saturating count of lost frames instead.

Read data is combinational from the address in the same cycle. Every side effect of a read (a pop or a sticky clear) takes place at the clock edge that ends the read cycle.

Top module: `rx_frame_status_queue`

## Requirements
- R1: After reset the status byte, the low length byte and the high length byte all read 0x00, and the lost-frame count reads 0.
- R2: A cycle with `frameDone` high and room in the queue stores `frameLen`, `crcErr` and `phyErr` as a new entry. Entries are returned oldest first.
- R3: Address 0 returns the status byte. Bit 7 is 1 exactly when the queue holds at least one entry. Bit 6 is lost-frame. Bit 5 reads 0. Bit 4 is over-length, bit 3 physical error and bit 2 CRC error, all three taken from the oldest entry and read as 0 when the queue is empty. Bit 1 is receive-data overrun and bit 0 is status-queue overrun.
- R4: An entry's over-length flag is 1 exactly when its `frameLen` is strictly greater than `maxLen` as sampled with `frameDone`.
- R5: With `cntMode` at 0, address 1 returns length bits 7:0 of the oldest entry. Address 2 returns length bits 12:8 in bits 4:0, with bits 7:5 at 0.
- R6: A read of address 2 while the queue is not empty removes the oldest entry. Reads of addresses 0 and 1 never remove an entry.
- R7: With the queue empty, reads of addresses 1 (with `cntMode` at 0) and 2 return 0x00 and leave the queue unchanged, so a frame pushed afterwards is the next one read.
- R8: A `frameDone` while the queue holds DEPTH entries and no pop occurs in that cycle is discarded. It sets the lost-frame and status-queue-overrun bits and adds one to the lost-frame count, which stops at 2^LOST_W-1.
- R9: A `frameDone` in the same cycle as a popping read of address 2 is always accepted, even when the queue is full. The occupancy is unchanged and no overrun is flagged.
- R10: Status bits 6, 1 and 0 stay set until the status byte is read, and that read clears them. A setting event in the same cycle as the clearing read leaves the bit set.
- R11: With `cntMode` at 1, address 1 returns the lost-frame count, zero-extended to 8 bits. Reading it does not clear it.
- R12: A one-cycle pulse on `rxOverrun` sets status bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameDone | input | 1 | End-of-frame strobe from the framer |
| frameLen | input | LEN_W | Byte count of the frame just ended |
| crcErr | input | 1 | Frame ended with a bad CRC |
| phyErr | input | 1 | Frame saw a physical-layer error |
| rxOverrun | input | 1 | Receive data buffer overrun pulse |
| maxLen | input | LEN_W | Programmed maximum frame length |
| cntMode | input | 1 | 1: address 1 returns lost-frame count |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdAddr | input | 2 | 0 status, 1 length low / lost count, 2 length high |
| rdData | output | 8 | Read data for the current address |

## Verification
The bench builds the block with DEPTH = 4 and LOST_W = 3. With these values the full-queue boundary is reached after four frames, and the lost-frame count saturates at 7 after a short burst of extra frames. The over-length compare is swept with the lengths either side of several maximum values, including 0 and 8191. A coarse stride covers the whole 13-bit length range, so both length bytes are exercised. Simultaneous push and pop are driven at both full and partly filled occupancy, where the small depth makes the pointer wrap happen often.

// File: rtl/rxfsq_pkg.sv
package rxfsq_pkg;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic push;       // store the incoming frame entry at the write pointer
    logic pop;        // retire the entry at the read pointer
    logic drop;       // incoming frame discarded: queue full
    logic clrSticky;  // status byte being read
  } fsqStrobe_t;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_LEN_LO = 2'd1;
  localparam logic [1:0] ADDR_LEN_HI = 2'd2;

endpackage

// File: rtl/rxfsq_ctrl.sv
module rxfsq_ctrl
  import rxfsq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  input  logic             rdEn,
  input  logic [1:0]       rdAddr,
  output fsqStrobe_t       strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] occupancy
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic isFull;
  logic isEmpty;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
  endfunction

  assign isFull  = (occupancy == FULL_CNT);
  assign isEmpty = (occupancy == '0);

  always_comb begin
    strobe.pop       = rdEn && (rdAddr == ADDR_LEN_HI) && !isEmpty;
    strobe.push      = frameDone && (!isFull || strobe.pop);
    strobe.drop      = frameDone && isFull && !strobe.pop;
    strobe.clrSticky = rdEn && (rdAddr == ADDR_STATUS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occupancy <= '0;
    end else begin
      unique case ({strobe.push, strobe.pop})
        2'b10:   occupancy <= occupancy + CNT_W'(1);
        2'b01:   occupancy <= occupancy - CNT_W'(1);
        default: occupancy <= occupancy;
      endcase
    end
  end

endmodule

// File: rtl/rxfsq_datapath.sv
module rxfsq_datapath
  import rxfsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 13,
  parameter int LOST_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENT_W = LEN_W + 3,
  localparam int HI_W  = LEN_W - 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fsqStrobe_t       strobe,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic             notEmpty,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             crcErr,
  input  logic             phyErr,
  input  logic             rxOverrun,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             cntMode,
  input  logic [1:0]       rdAddr,
  output logic [7:0]       rdData
);

  // Entry layout: {overLen, phy, crc, length}
  logic [ENT_W-1:0]  slotArr [DEPTH];
  logic [ENT_W-1:0]  newEntry;
  logic [ENT_W-1:0]  headEntry;
  logic [LEN_W-1:0]  headLen;
  logic              headOver;
  logic              headPhy;
  logic              headCrc;

  logic              lostQ;
  logic              rxOvQ;
  logic              fsqOvQ;
  logic [LOST_W-1:0] lostCnt;

  logic [7:0] statusByte;
  logic [7:0] lenLoByte;
  logic [7:0] lenHiByte;

  assign newEntry = {(frameLen > maxLen), phyErr, crcErr, frameLen};

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [ENT_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (strobe.push && (wrPtr == PTR_W'(e))) begin
        slotQ <= newEntry;
      end else if (strobe.pop && (rdPtr == PTR_W'(e))) begin
        slotQ <= '0;
      end
    end
    assign slotArr[e] = slotQ;
  end

  assign headEntry = slotArr[rdPtr];
  assign headLen   = headEntry[LEN_W-1:0];
  assign headCrc   = headEntry[LEN_W];
  assign headPhy   = headEntry[LEN_W+1];
  assign headOver  = headEntry[LEN_W+2];

  // Sticky flags: a set in the clearing cycle wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lostQ  <= 1'b0;
      rxOvQ  <= 1'b0;
      fsqOvQ <= 1'b0;
    end else begin
      lostQ  <= (lostQ  && !strobe.clrSticky) || strobe.drop;
      rxOvQ  <= (rxOvQ  && !strobe.clrSticky) || rxOverrun;
      fsqOvQ <= (fsqOvQ && !strobe.clrSticky) || strobe.drop;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lostCnt <= '0;
    end else if (strobe.drop && (lostCnt != '1)) begin
      lostCnt <= lostCnt + LOST_W'(1);
    end
  end

  always_comb begin
    statusByte = {notEmpty,
                  lostQ,
                  1'b0,
                  notEmpty && headOver,
                  notEmpty && headPhy,
                  notEmpty && headCrc,
                  rxOvQ,
                  fsqOvQ};
    lenLoByte  = notEmpty ? headLen[7:0] : 8'h00;
    lenHiByte  = notEmpty ? 8'(headLen[LEN_W-1:8]) : 8'h00;
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_STATUS: rdData = statusByte;
      ADDR_LEN_LO: rdData = cntMode ? 8'(lostCnt) : lenLoByte;
      ADDR_LEN_HI: rdData = lenHiByte;
      default:     rdData = 8'h00;
    endcase
  end

  if (HI_W < 1 || HI_W > 8 || LOST_W > 8) begin : g_bad_param
    initial $error("rxfsq_datapath: LEN_W must be 9..16 and LOST_W at most 8");
  end

endmodule

// File: rtl/rx_frame_status_queue.sv
module rx_frame_status_queue
  import rxfsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 13,
  parameter int LOST_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             crcErr,
  input  logic             phyErr,
  input  logic             rxOverrun,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             cntMode,
  input  logic             rdEn,
  input  logic [1:0]       rdAddr,
  output logic [7:0]       rdData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  fsqStrobe_t       strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] occupancy;

  rxfsq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameDone (frameDone),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .strobe    (strobe),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .occupancy (occupancy)
  );

  rxfsq_datapath #(.DEPTH(DEPTH), .LEN_W(LEN_W), .LOST_W(LOST_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .notEmpty  (occupancy != '0),
    .frameLen  (frameLen),
    .crcErr    (crcErr),
    .phyErr    (phyErr),
    .rxOverrun (rxOverrun),
    .maxLen    (maxLen),
    .cntMode   (cntMode),
    .rdAddr    (rdAddr),
    .rdData    (rdData)
  );

endmodule

// File: rtl/rxfsq_checker.sv
module rxfsq_checker #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameDone,
  input logic             rdEn,
  input logic [1:0]       rdAddr,
  input logic [7:0]       rdData,
  input logic [CNT_W-1:0] occupancy
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= FULL_CNT); // R8

  AST_READY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'd0) |-> (rdData[7] == (occupancy != '0))); // R3

  AST_STATUS_RSV: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'd0) |-> (rdData[5] == 1'b0)); // R3

  AST_EMPTY_LEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'd2 && occupancy == '0) |-> (rdData == 8'h00)); // R7

  AST_HI_PAD: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'd2) |-> (rdData[7:5] == 3'b000)); // R5

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'd2 && occupancy != '0 && !frameDone)
      |=> (occupancy == $past(occupancy) - CNT_W'(1))); // R6

  AST_SIMUL_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'd2 && occupancy != '0 && frameDone)
      |=> $stable(occupancy)); // R9

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && occupancy == FULL_CNT && !(rdEn && rdAddr == 2'd2))
      |=> (occupancy == FULL_CNT)); // R8

  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == '0 && !frameDone) |=> (occupancy == '0)); // R7

endmodule

bind rx_frame_status_queue rxfsq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameDone (frameDone),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .occupancy (occupancy)
);

// File: tb/rx_frame_status_queue_tb.sv
module rx_frame_status_queue_tb;

  localparam int DEPTH    = 4;
  localparam int LEN_W    = 13;
  localparam int LOST_W   = 3;
  localparam int LOST_MAX = (1 << LOST_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             frameDone = 1'b0;
  logic [LEN_W-1:0] frameLen = '0;
  logic             crcErr = 1'b0;
  logic             phyErr = 1'b0;
  logic             rxOverrun = 1'b0;
  logic [LEN_W-1:0] maxLen = '0;
  logic             cntMode = 1'b0;
  logic             rdEn = 1'b0;
  logic [1:0]       rdAddr = 2'd0;
  logic [7:0]       rdData;

  int  testsRun = 0;
  int  testsFailed = 0;

  // Reference model
  int  qLen[$];
  bit  qCrc[$];
  bit  qPhy[$];
  bit  qOvr[$];
  bit  mLost = 0;
  bit  mRx = 0;
  bit  mFsq = 0;
  int  mCnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  rx_frame_status_queue #(.DEPTH(DEPTH), .LEN_W(LEN_W), .LOST_W(LOST_W)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .frameDone (frameDone),
    .frameLen  (frameLen),
    .crcErr    (crcErr),
    .phyErr    (phyErr),
    .rxOverrun (rxOverrun),
    .maxLen    (maxLen),
    .cntMode   (cntMode),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .rdData    (rdData)
  );

  function automatic logic [7:0] expByte(input int a);
    bit ne = (qLen.size() > 0);
    case (a)
      0: return {ne, mLost, 1'b0, ne && qOvr[0], ne && qPhy[0], ne && qCrc[0], mRx, mFsq};
      1: return cntMode ? 8'(mCnt) : (ne ? 8'(qLen[0] & 255) : 8'h00);
      2: return ne ? 8'((qLen[0] >> 8) & 31) : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input int a, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s addr%0d actual=%02h expected=%02h", tag, a, act, exp);
    end
  endtask

  task automatic modelPop();
    if (qLen.size() > 0) begin
      void'(qLen.pop_front()); void'(qCrc.pop_front());
      void'(qPhy.pop_front()); void'(qOvr.pop_front());
    end
  endtask

  task automatic modelPush(input int len, input bit c, input bit p);
    if (qLen.size() >= DEPTH) begin
      mLost = 1; mFsq = 1;
      if (mCnt < LOST_MAX) mCnt++;
    end else begin
      qLen.push_back(len); qCrc.push_back(c); qPhy.push_back(p);
      qOvr.push_back(len > int'(maxLen));
    end
  endtask

  task automatic readChk(input int a, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 2'(a);
    #1;
    exp = expByte(a);
    check(tag, a, rdData, exp);
    @(negedge clk);
    rdEn = 1'b0;
    if (a == 0) begin mLost = 0; mRx = 0; mFsq = 0; end
    if (a == 2) modelPop();
  endtask

  task automatic pushFrame(input int len, input bit c, input bit p);
    @(negedge clk);
    frameDone = 1'b1; frameLen = LEN_W'(len); crcErr = c; phyErr = p;
    @(negedge clk);
    frameDone = 1'b0; crcErr = 1'b0; phyErr = 1'b0;
    modelPush(len, c, p);
  endtask

  // Pop (address 2 read) and push in the same cycle
  task automatic pushPop(input int len, input bit c, input bit p, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 2'd2;
    frameDone = 1'b1; frameLen = LEN_W'(len); crcErr = c; phyErr = p;
    #1;
    exp = expByte(2);
    check(tag, 2, rdData, exp);
    @(negedge clk);
    rdEn = 1'b0; frameDone = 1'b0; crcErr = 1'b0; phyErr = 1'b0;
    modelPop();
    modelPush(len, c, p);
  endtask

  task automatic drainChk(input string tag);
    while (qLen.size() > 0) begin
      readChk(0, tag);
      readChk(1, tag);
      readChk(2, tag);
    end
    readChk(0, tag);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stim
    int maxSet[4];
    maxSet[0] = 0; maxSet[1] = 100; maxSet[2] = 4000; maxSet[3] = 8191;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    readChk(0, "R1");
    readChk(1, "R1");
    readChk(2, "R1");
    cntMode = 1'b1;
    readChk(1, "R1");
    cntMode = 1'b0;

    // R2 R3 R4 R5 R6: boundary lengths around several maxima, all flag pairs
    for (int m = 0; m < 4; m++) begin
      maxLen = LEN_W'(maxSet[m]);
      for (int i = 0; i < DEPTH; i++) begin
        int len;
        len = (i == 3) ? ((maxSet[m] * 7 + 1234) & 8191) : ((maxSet[m] + i - 1) & 8191);
        pushFrame(len, i[0], i[1]);
      end
      readChk(1, "R6");  // non-popping reads leave head in place
      readChk(0, "R6");
      readChk(1, "R6");
      drainChk("R4");
    end

    // R5 R2: stride sweep over the full length range
    maxLen = 13'd4096;
    for (int len = 0; len < 8192; len += 97) begin
      pushFrame(len, len[2], len[3]);
      readChk(0, "R3");
      readChk(1, "R5");
      readChk(2, "R5");
    end
    pushFrame(8191, 1, 1);
    drainChk("R5");

    // R7: empty reads, pointers untouched
    readChk(2, "R7");
    readChk(2, "R7");
    readChk(1, "R7");
    pushFrame(300, 1, 0);
    pushFrame(5000, 0, 1);
    drainChk("R7");

    // R8 R10 R11: overflow, sticky clear, lost count
    for (int i = 0; i < DEPTH + 3; i++) pushFrame(i * 11 + 5, 0, 0);
    readChk(0, "R8");
    readChk(0, "R10");
    cntMode = 1'b1;
    readChk(1, "R11");
    readChk(1, "R11");
    for (int i = 0; i < 10; i++) pushFrame(77, 1, 1);
    readChk(1, "R8");
    readChk(0, "R8");
    cntMode = 1'b0;
    drainChk("R8");

    // R9: simultaneous push and pop, full and partial
    for (int i = 0; i < DEPTH; i++) pushFrame(1000 + i, 0, 1);
    for (int i = 0; i < 6; i++) pushPop(2000 + i * 3, i[0], 0, "R9");
    readChk(0, "R9");
    drainChk("R9");
    pushFrame(42, 0, 0);
    pushPop(43, 1, 1, "R9");
    readChk(0, "R9");
    pushPop(44, 0, 0, "R9");
    drainChk("R9");

    // R12: overrun pulse, and set-wins-over-clear
    @(negedge clk); rxOverrun = 1'b1;
    @(negedge clk); rxOverrun = 1'b0;
    mRx = 1;
    readChk(0, "R12");
    readChk(0, "R12");
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 2'd0; rxOverrun = 1'b1;
    #1;
    check("R10", 0, rdData, expByte(0));
    @(negedge clk);
    rdEn = 1'b0; rxOverrun = 1'b0;
    mLost = 0; mFsq = 0; mRx = 1;
    readChk(0, "R10");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule